// File: doc/BRIEF.md
# Link Power Monitor and Wake Signaller

This block sits between the cable-side logic of a PHY and its link-layer controller. It watches the link's power-status input through a two-flop synchronizer and times each inactive interval in system-clock cycles. A short gap is treated as a glitch and ignored. A medium gap makes the block send a one-cycle reset pulse to the PHY-to-link interface when the link comes back. A long gap switches the interface off until the link reports power again.

While the interface is off, the block can wake the link by driving a square wave on its wake output. Three kinds of cause start the wave. The first is a link-on packet strobe for this node. The second is a port-event interrupt bit. The third is any of the timeout, power-fail or loop bits, but only when the resume-interrupt bit is also set. The wave stops when the link returns. A bus reset stops it early only when the packet strobe was its sole cause. Interrupt causes are levels. If one is present while the link is still powered, the wave starts as soon as the interface is switched off.

The wave is the system clock divided by eight. For a 49.152 MHz system clock this gives about 6.1 MHz.

Top module: `link_wake_ctrl`

## Requirements
- R1: After reset, if_en_o is 1, if_rst_o is 0 and lkon_o is 0.
- R2: A low interval on lps_i of fewer than SHORT_CYC clock cycles (default 59) gives no pulse on if_rst_o and leaves if_en_o at 1.
- R3: A low interval of N cycles, with SHORT_CYC <= N < LONG_CYC (default 1229), gives exactly one if_rst_o pulse, one cycle wide, after lps_i returns high. if_en_o stays 1 throughout.
- R4: A low interval of LONG_CYC cycles or more drops if_en_o to 0 while lps_i is still low. No if_rst_o pulse follows when lps_i returns high.
- R5: When lps_i returns high after a disabling interval, if_en_o goes back to 1 within a few cycles.
- R6: lkon_o toggles only while the interface is disabled. A lkon_pkt_i strobe that arrives while if_en_o is 1 is ignored and does not wake the link later.
- R7: A lkon_pkt_i strobe while the interface is disabled starts the wake wave. The wave runs until lps_i returns high.
- R8: The wake wave has a period of WAKE_DIV cycles (default 8): half the period high and half low, with no high run longer than WAKE_DIV/2.
- R9: port_evt_i = 1 while the interface is disabled starts the wake wave.
- R10: timeout_i, pwr_fail_i or loop_i starts the wake wave only when resume_int_i is also 1.
- R11: bus_rst_i stops the wake wave when lkon_pkt_i alone started it. It has no effect while an interrupt cause is present.
- R12: An interrupt cause that is present while lps_i is high raises no wake wave. The wave starts once a long low interval disables the interface.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lps_i | input | 1 | Link power status, high = link powered (asynchronous) |
| lkon_pkt_i | input | 1 | One-cycle strobe: link-on packet for this node received |
| bus_rst_i | input | 1 | One-cycle strobe: bus reset occurred |
| port_evt_i | input | 1 | Port-event interrupt bit |
| timeout_i | input | 1 | Timeout interrupt bit |
| pwr_fail_i | input | 1 | Power-fail interrupt bit |
| loop_i | input | 1 | Loop interrupt bit |
| resume_int_i | input | 1 | Resume-interrupt enable bit |
| if_rst_o | output | 1 | One-cycle reset pulse to the PHY-to-link interface |
| if_en_o | output | 1 | PHY-to-link interface enable |
| lkon_o | output | 1 | Wake wave to the link |

## Verification
The hardest situations to reach from the ports are the threshold edges: intervals of exactly SHORT_CYC-1, SHORT_CYC, LONG_CYC-1 and LONG_CYC cycles. The two-cycle synchronizer delay must cancel out so that the run length seen by the timer equals the number of low clock edges the bench drives. A table of interval lengths walks those edges. The bench drives lps_i at the falling edge and samples both outputs in the same loop.

The bus-reset and interrupt-ordering cases build on this. The bench first holds lps_i low past the long threshold to disable the interface. It then layers packet strobes, interrupt levels and bus resets on top. Each time it counts high cycles of lkon_o over a fixed window.

// File: rtl/lw_pkg.sv
package lw_pkg;
  typedef struct packed {
    logic port_evt;
    logic timeout;
    logic pwr_fail;
    logic loop;
    logic resume;
  } irq_bits_t;

  function automatic logic irq_wakes(irq_bits_t b);
    return b.port_evt | (b.resume & (b.timeout | b.pwr_fail | b.loop));
  endfunction
endpackage

// File: rtl/lw_sync.sv
module lw_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/lw_idle_timer.sv
module lw_idle_timer #(
  parameter int unsigned SHORT_CYC = 59,
  parameter int unsigned LONG_CYC  = 1229
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lps_s_i,
  output logic if_rst_o,
  output logic if_en_o
);
  localparam int unsigned CW = $clog2(LONG_CYC + 1);
  localparam logic [CW-1:0] SHORT_V = CW'(SHORT_CYC);
  localparam logic [CW-1:0] LONG_V  = CW'(LONG_CYC);

  logic [CW-1:0] run_q;
  logic          en_q;
  logic          rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      en_q  <= 1'b1;
      rst_q <= 1'b0;
    end else if (lps_s_i) begin
      // link powered: judge the interval that just ended
      rst_q <= (run_q >= SHORT_V) && (run_q < LONG_V);
      run_q <= '0;
      en_q  <= 1'b1;
    end else begin
      rst_q <= 1'b0;
      if (run_q != LONG_V) run_q <= run_q + 1'b1;
      if (run_q >= LONG_V - 1'b1) en_q <= 1'b0;
    end
  end

  assign if_rst_o = rst_q;
  assign if_en_o  = en_q;
endmodule

// File: rtl/lw_wake_gen.sv
module lw_wake_gen #(
  parameter int unsigned WAKE_DIV = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              if_en_i,
  input  logic              lkon_pkt_i,
  input  logic              bus_rst_i,
  input  lw_pkg::irq_bits_t irq_i,
  output logic              lkon_o
);
  localparam int unsigned DW = $clog2(WAKE_DIV);

  logic          pkt_q;
  logic          act_q;
  logic [DW-1:0] div_q;
  logic          irq_cause;

  assign irq_cause = lw_pkg::irq_wakes(irq_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pkt_q <= 1'b0;
      act_q <= 1'b0;
      div_q <= '0;
    end else begin
      if (if_en_i)         pkt_q <= 1'b0;
      else if (lkon_pkt_i) pkt_q <= 1'b1;
      else if (bus_rst_i)  pkt_q <= 1'b0;

      act_q <= !if_en_i && (pkt_q || irq_cause);

      if (!act_q) div_q <= '0;
      else        div_q <= div_q + 1'b1;
    end
  end

  assign lkon_o = act_q & div_q[DW-1];
endmodule

// File: rtl/link_wake_ctrl.sv
module link_wake_ctrl #(
  parameter int unsigned SHORT_CYC = 59,
  parameter int unsigned LONG_CYC  = 1229,
  parameter int unsigned WAKE_DIV  = 8,
  parameter int unsigned SYNC_STG  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lps_i,
  input  logic lkon_pkt_i,
  input  logic bus_rst_i,
  input  logic port_evt_i,
  input  logic timeout_i,
  input  logic pwr_fail_i,
  input  logic loop_i,
  input  logic resume_int_i,
  output logic if_rst_o,
  output logic if_en_o,
  output logic lkon_o
);
  logic              lps_s;
  lw_pkg::irq_bits_t irq;

  assign irq = '{port_evt: port_evt_i, timeout: timeout_i,
                 pwr_fail: pwr_fail_i, loop: loop_i, resume: resume_int_i};

  lw_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(lps_i), .q_o(lps_s)
  );

  lw_idle_timer #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .lps_s_i(lps_s),
    .if_rst_o(if_rst_o), .if_en_o(if_en_o)
  );

  lw_wake_gen #(.WAKE_DIV(WAKE_DIV)) u_wake (
    .clk_i(clk_i), .rst_ni(rst_ni), .if_en_i(if_en_o),
    .lkon_pkt_i(lkon_pkt_i), .bus_rst_i(bus_rst_i), .irq_i(irq),
    .lkon_o(lkon_o)
  );
endmodule

// File: rtl/link_wake_ctrl_chk.sv
module link_wake_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic if_rst_o,
  input logic if_en_o,
  input logic lkon_o
);
  // R3: reset pulse lasts one cycle
  assert_rst_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    if_rst_o |=> !if_rst_o);
  // R3: interface stays enabled while the reset pulse is driven
  assert_rst_enabled_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    if_rst_o |-> if_en_o);
  // R4: no reset pulse right after a disabled cycle
  assert_no_rst_after_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    if_rst_o |-> $past(if_en_o));
  // R6: wake wave only follows a disabled interface
  assert_wake_when_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkon_o |-> !$past(if_en_o));
endmodule

bind link_wake_ctrl link_wake_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .if_rst_o(if_rst_o),
  .if_en_o(if_en_o), .lkon_o(lkon_o)
);

// File: tb/link_wake_ctrl_tb_top.sv
`timescale 1ns/1ps
module link_wake_ctrl_tb_top;
  localparam int SHORT = 59;
  localparam int LONG  = 1229;
  localparam int NV    = 8;
  localparam int LEN     [NV] = '{3, 58, 59, 300, 1228, 1229, 1500, 20};
  localparam int EXP_RST [NV] = '{0, 0, 1, 1, 1, 0, 0, 0};
  localparam int EXP_OFF [NV] = '{0, 0, 0, 0, 0, 1, 1, 0};

  logic clk = 1'b0, rst_n = 1'b0;
  logic lps = 1'b1, pkt = 1'b0, brst = 1'b0;
  logic pev = 1'b0, tmo = 1'b0, pwf = 1'b0, lop = 1'b0, rsm = 1'b0;
  logic if_rst, if_en, lkon;
  int n_cmp = 0, n_bad = 0;
  int rst_seen, off_seen, hi_cnt, run, max_run;
  bit done = 1'b0;

  always #10 clk = ~clk;

  link_wake_ctrl #(.SHORT_CYC(SHORT), .LONG_CYC(LONG)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .lps_i(lps), .lkon_pkt_i(pkt),
    .bus_rst_i(brst), .port_evt_i(pev), .timeout_i(tmo),
    .pwr_fail_i(pwf), .loop_i(lop), .resume_int_i(rsm),
    .if_rst_o(if_rst), .if_en_o(if_en), .lkon_o(lkon)
  );

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    rst_seen = 0; off_seen = 0; hi_cnt = 0; run = 0; max_run = 0;
  endtask

  task automatic sample();
    @(negedge clk);
    rst_seen += int'(if_rst);
    if (!if_en) off_seen = 1;
    hi_cnt += int'(lkon);
    run = lkon ? run + 1 : 0;
    if (run > max_run) max_run = run;
  endtask

  task automatic observe(int n);
    clear_mon();
    for (int i = 0; i < n; i++) sample();
  endtask

  task automatic idle_run(int len);
    clear_mon();
    @(negedge clk); lps = 1'b0;
    for (int i = 0; i < len; i++) sample();
    lps = 1'b1;
    for (int i = 0; i < 12; i++) sample();
  endtask

  task automatic go_off();
    @(negedge clk); lps = 1'b0;
    repeat (LONG + 20) @(negedge clk);
  endtask

  task automatic go_on();
    lps = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic strobe(ref logic s);
    s = 1'b1; @(negedge clk); s = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 if_en", int'(if_en), 1);
    check("R1 if_rst", int'(if_rst), 0);
    check("R1 lkon", int'(lkon), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 R3 R4 R5: interval table
    for (int v = 0; v < NV; v++) begin
      idle_run(LEN[v]);
      check($sformatf("R2/R3/R4 rst pulses len=%0d", LEN[v]), rst_seen, EXP_RST[v]);
      check($sformatf("R4 disabled len=%0d", LEN[v]), off_seen, EXP_OFF[v]);
      check($sformatf("R5 enabled after len=%0d", LEN[v]), int'(if_en), 1);
      check("R6 no wake without cause", hi_cnt, 0);
    end

    // R7 R8: packet wake
    go_off();
    check("R4 off while low", int'(if_en), 0);
    strobe(pkt);
    repeat (4) @(negedge clk);
    observe(80);
    check("R7 wake high cycles", hi_cnt, 40);
    check("R8 max high run", max_run, 4);
    // R11 bus reset stops packet-only wake
    strobe(brst);
    repeat (4) @(negedge clk);
    observe(40);
    check("R11 bus reset stops pkt wake", hi_cnt, 0);
    go_on();

    // R7: wake persists until LPS active, then stops
    go_off();
    strobe(pkt);
    repeat (300) @(negedge clk);
    observe(40);
    check("R7 still waking", hi_cnt, 20);
    go_on();
    observe(40);
    check("R7 stops on lps active", hi_cnt, 0);

    // R9 R11: port event holds through bus reset
    go_off();
    strobe(pkt);
    pev = 1'b1;
    strobe(brst);
    repeat (4) @(negedge clk);
    observe(40);
    check("R11 bus reset ignored with irq", hi_cnt, 20);
    check("R9 port event wake", max_run, 4);
    go_on();
    pev = 1'b0;
    observe(20);
    check("R9 stopped after return", hi_cnt, 0);

    // R10: timeout without resume -> nothing; with resume -> wake
    go_off();
    tmo = 1'b1; pwf = 1'b1; lop = 1'b1;
    observe(40);
    check("R10 no wake without resume", hi_cnt, 0);
    rsm = 1'b1;
    repeat (4) @(negedge clk);
    observe(40);
    check("R10 wake with resume", hi_cnt, 20);
    tmo = 1'b0; pwf = 1'b0;
    repeat (4) @(negedge clk);
    observe(40);
    check("R10 loop alone with resume", hi_cnt, 20);
    lop = 1'b0;
    repeat (4) @(negedge clk);
    observe(40);
    check("R10 wake ends when cause clears", hi_cnt, 0);
    go_on();
    rsm = 1'b0;

    // R12: interrupt present while link powered
    pev = 1'b1;
    observe(100);
    check("R12 no wake while powered", hi_cnt, 0);
    go_off();
    observe(40);
    check("R12 wake once disabled", hi_cnt, 20);
    go_on();
    pev = 1'b0;

    // R6: packet strobe while enabled is ignored
    strobe(pkt);
    go_off();
    observe(80);
    check("R6 early packet ignored", hi_cnt, 0);
    go_on();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule